// File: doc/BRIEF.md
# Fast-Fault Shutdown Controller

This clocked controller protects a half-bridge. It watches a fault-comparator trip flag, an undervoltage-lockout status and a shared shutdown line that is wired open-drain. The line reaches the block as two flags from a Schmitt-trigger front end: one says the line is below the low threshold, the other says it is above the high threshold. The block drives two outputs. One is a gate-enable for the output stage. The other is a pull-down request for the open-drain device on the shared line.

A trip removes the gate-enable at once, in the cycle the synchronised trip is first seen. The block does not wait for the shared line to discharge. It then pulls the line down until the line is seen below its low threshold. At that point the pull-down is released so the external pull-up can recharge the line. The gate stays off until the line is seen above its high threshold.

A low level that something else drives onto the line is never latched. It turns the gate off only while it lasts, so a PWM signal on the line chops the output stage. The trip input is ignored while undervoltage lockout is active. Recovery is sequenced by a registered three-state controller: discharge, wait-for-high and run.

Top module: `ffsd_top`

## Requirements
- R1: Two clock edges after `trip_in` rises, with `uvlo` low, `gate_en` is low in that same cycle. This holds whatever the state of the line flags.
- R2: One edge after that, `pd_req` goes high. It stays high for as long as the synchronised low-threshold flag is clear.
- R3: While the pull-down is active and no trip is present, `pd_req` drops one edge after the synchronised low-threshold flag is seen high.
- R4: After the pull-down releases, `gate_en` stays low until the high-threshold flag is seen. It rises three edges after `line_high_in` rises.
- R5: A low-threshold flag seen while running drops `gate_en` two edges after `line_low_in` rises, and it does not assert `pd_req`. The gate returns when the high flag is seen, so repeated low/high toggling (PWM) switches `gate_en` off and on.
- R6: While `uvlo` is high, `trip_in` has no effect on `gate_en` or `pd_req`.
- R7: A trip in the wait-for-high state re-enters discharge (`pd_req` high). A trip takes priority over a high-threshold flag that arrives in the same cycle.
- R8: Every input flag passes through a synchroniser of `SYNC_STAGES` flops (default 2). No input has an effect on `gate_en` until two edges after the input changes.
- R9: After reset the block is in wait-for-high. `gate_en` and `pd_req` are both low, and the gate stays off until the high-threshold flag is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_in | input | 1 | Fault-comparator trip flag (asynchronous) |
| line_low_in | input | 1 | Shared line below low threshold (asynchronous) |
| line_high_in | input | 1 | Shared line above high threshold (asynchronous) |
| uvlo | input | 1 | Undervoltage lockout active; masks the trip |
| gate_en | output | 1 | Enable for the half-bridge output stage |
| pd_req | output | 1 | Request to turn on the shared line's open-drain pull-down |

## Verification
A trip and a recovery threshold can land in the same cycle. In wait-for-high, the bench raises `trip_in` and `line_high_in` on the same edge. The design passes only if it enters discharge (`pd_req` high, `gate_en` low) and does not enter run. In the same way, the vector table clears a trip on the very edge where the low-threshold flag rises. The controller must then release the pull-down and wait for the high flag, with `gate_en` held low throughout.

// File: rtl/ffsd_pkg.sv
package ffsd_pkg;
   typedef enum logic [1:0] {
      ST_DISCHARGE = 2'd0,
      ST_WAIT_HIGH = 2'd1,
      ST_RUN       = 2'd2
   } ffsd_state_e;

   localparam int unsigned FLAG_COUNT = 3;
   localparam int unsigned FLAG_TRIP  = 0;
   localparam int unsigned FLAG_LOW   = 1;
   localparam int unsigned FLAG_HIGH  = 2;
endpackage

// File: rtl/ffsd_sync.sv
module ffsd_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 3,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ffsd_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ffsd_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= RESET_VAL;
               else        pipe[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= RESET_VAL;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[LAST];
endmodule

// File: rtl/ffsd_fsm.sv
module ffsd_fsm
   import ffsd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trip_s,
   input  logic low_s,
   input  logic high_s,
   input  logic uvlo,
   output logic gate_en,
   output logic pd_req
);
   ffsd_state_e state_q, state_d;
   logic        trip_eff;

   // the lockout masks the comparator path entirely
   assign trip_eff = trip_s & ~uvlo;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_DISCHARGE: if (!trip_eff && low_s) state_d = ST_WAIT_HIGH;
         ST_WAIT_HIGH: begin
            if (trip_eff)    state_d = ST_DISCHARGE;
            else if (high_s) state_d = ST_RUN;
         end
         ST_RUN: begin
            if (trip_eff)   state_d = ST_DISCHARGE;
            else if (low_s) state_d = ST_WAIT_HIGH;
         end
         default: state_d = ST_WAIT_HIGH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_WAIT_HIGH;
      else        state_q <= state_d;
   end

   // kill path bypasses the state register
   assign gate_en = (state_q == ST_RUN) & ~trip_eff & ~low_s;
   assign pd_req  = (state_q == ST_DISCHARGE);

   p_trip_pulls_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trip_eff |=> pd_req);

   p_release_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req && low_s && !trip_eff |=> !pd_req);

   p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en && !high_s |=> !gate_en);

   p_ext_low_no_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) && low_s && !trip_eff |=> !pd_req);

   p_uvlo_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo && !pd_req |=> !pd_req);

   p_trip_beats_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trip_eff && high_s |=> !gate_en && pd_req);
endmodule

// File: rtl/ffsd_top.sv
module ffsd_top
   import ffsd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_in,
   input  logic line_low_in,
   input  logic line_high_in,
   input  logic uvlo,
   output logic gate_en,
   output logic pd_req
);
   logic [FLAG_COUNT-1:0] raw_flags, sync_flags;

   assign raw_flags[FLAG_TRIP] = trip_in;
   assign raw_flags[FLAG_LOW]  = line_low_in;
   assign raw_flags[FLAG_HIGH] = line_high_in;

   ffsd_sync #(
      .STAGES   (SYNC_STAGES),
      .WIDTH    (FLAG_COUNT),
      .RESET_VAL('0)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_flags),
      .q    (sync_flags)
   );

   ffsd_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .trip_s (sync_flags[FLAG_TRIP]),
      .low_s  (sync_flags[FLAG_LOW]),
      .high_s (sync_flags[FLAG_HIGH]),
      .uvlo   (uvlo),
      .gate_en(gate_en),
      .pd_req (pd_req)
   );

   p_immediate_kill_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_flags[FLAG_TRIP]) && !uvlo |-> !gate_en);
endmodule

// File: tb/ffsd_top_test.sv
module ffsd_top_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trip_in = 1'b0, line_low_in = 1'b0, line_high_in = 1'b0, uvlo = 1'b0;
   logic gate_en, pd_req;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   ffsd_top uut (
      .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .line_low_in(line_low_in),
      .line_high_in(line_high_in), .uvlo(uvlo), .gate_en(gate_en), .pd_req(pd_req)
   );

   // {req, trip, low, high, uvlo, exp_gate, exp_pd}
   localparam logic [9:0] VEC [0:13] = '{
      {4'd4, 6'b001010},  // R4 high flag -> run
      {4'd2, 6'b101001},  // R2 trip -> discharge
      {4'd2, 6'b000001},  // R2 line mid, pull-down held
      {4'd3, 6'b010000},  // R3 below low -> release
      {4'd4, 6'b000000},  // R4 mid, still off
      {4'd4, 6'b001010},  // R4 high -> run
      {4'd5, 6'b010000},  // R5 external low, no pull-down
      {4'd5, 6'b001010},  // R5 not latched, back on high
      {4'd6, 6'b101110},  // R6 trip masked by lockout
      {4'd1, 6'b101001},  // R1 lockout removed, held trip acts
      {4'd3, 6'b010000},  // R3 trip clears with low flag
      {4'd7, 6'b100001},  // R7 trip in wait re-enters discharge
      {4'd3, 6'b010000},  // R3 release again
      {4'd4, 6'b001010}   // R4 recover
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic t, input logic l, input logic h, input logic u);
      trip_in = t; line_low_in = l; line_high_in = h; uvlo = u;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      chk("R9", "gate after reset", gate_en, 1'b0);
      chk("R9", "pd after reset", pd_req, 1'b0);
      cyc(4);
      chk("R9", "gate stays off without high", gate_en, 1'b0);

      for (int i = 0; i < 14; i++) begin
         drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
         cyc(3);
         chk($sformatf("R%0d", VEC[i][9:6]), $sformatf("vector %0d gate", i), gate_en, VEC[i][1]);
         chk($sformatf("R%0d", VEC[i][9:6]), $sformatf("vector %0d pd", i), pd_req, VEC[i][0]);
      end

      // R8 / R1 / R2 latency from running
      drive(1, 0, 1, 0);
      cyc(1);
      chk("R8", "gate one edge after trip", gate_en, 1'b1);
      cyc(1);
      chk("R1", "gate two edges after trip", gate_en, 1'b0);
      chk("R2", "pd not yet", pd_req, 1'b0);
      cyc(1);
      chk("R2", "pd three edges after trip", pd_req, 1'b1);
      drive(0, 1, 0, 0); cyc(3);
      chk("R3", "released", pd_req, 1'b0);
      drive(0, 0, 1, 0); cyc(2);
      chk("R4", "gate two edges after high", gate_en, 1'b0);
      cyc(1);
      chk("R4", "gate three edges after high", gate_en, 1'b1);

      // R7 trip and high in the same cycle from wait-for-high
      drive(0, 1, 0, 0); cyc(3);
      drive(0, 0, 0, 0); cyc(3);
      drive(1, 0, 1, 0); cyc(3);
      chk("R7", "pd on simultaneous trip/high", pd_req, 1'b1);
      chk("R7", "gate on simultaneous trip/high", gate_en, 1'b0);
      drive(0, 0, 1, 0); cyc(3);
      chk("R2", "pd held while line not low", pd_req, 1'b1);
      chk("R4", "gate off during discharge", gate_en, 1'b0);
      drive(0, 1, 0, 0); cyc(3);
      drive(0, 0, 1, 0); cyc(3);
      chk("R4", "recovered", gate_en, 1'b1);

      // R5 PWM chopping through the line
      for (int p = 0; p < 4; p++) begin
         drive(0, 1, 0, 0); cyc(2);
         chk("R5", "pwm low gate", gate_en, 1'b0);
         chk("R5", "pwm low no pd", pd_req, 1'b0);
         cyc(1);
         drive(0, 0, 1, 0); cyc(3);
         chk("R5", "pwm high gate", gate_en, 1'b1);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule